// File: doc/BRIEF.md
# Transmit Path Component Reset Sequencer

This block drives the reset lines of four sub-blocks inside a serial transmitter: a clock-calibration stage, the physical-medium stage, the coding sublayer and the forward-error-correction stage. A master reset input is sampled through a synchroniser. Its falling edge starts a sequence that asserts the reset lines of the chosen sub-blocks and releases them once the PLL reports lock. The two selection inputs and the mode input are captured when the sequence starts. In staged mode the lines are released one at a time, with a programmable hold between releases. In simultaneous mode they are all released on the same edge. In staged mode the coding sublayer is not released until the user-ready input is high.

Four direct reset inputs act on their own sub-block only, whatever the selection and the mode. A direct input seen while a master sequence is running raises a sticky error flag. A done flag reports that the last release has taken place.

FSM states: `ST_IDLE` (waiting; also the resting state after completion), `ST_HOLD` (selected resets held for `HOLD_CYC` cycles), `ST_LOCK` (waiting for PLL lock), `ST_STEP` (staged release, one component per step), `ST_FIN` (one cycle before done rises). The transitions are:
- IDLE→HOLD on a synchronised falling edge of the master input.
- HOLD→LOCK when the hold count expires.
- LOCK→FIN in simultaneous mode, or LOCK→STEP in staged mode, once lock is high.
- STEP→FIN on the release of the last selected component.
- FIN→IDLE unconditionally.

Top module: `tx_rst_seq`

## Requirements
- R1: After `rst_n` is low, all four component reset outputs, `done_o` and `err_o` are low.
- R2: A master input held high for at least one clock and then lowered starts a sequence. About three clocks after the fall, every selected component reset output is high, `done_o` is low and `err_o` is cleared.
- R3: Selection follows two rules. `pma_sel_i` selects the calibration and physical-medium components, and `pcs_sel_i` selects the coding and error-correction components. With both low, all four are selected. An unselected output never goes high during the sequence.
- R4: No component is released while `pll_lock_i` is low. The first release comes at least `HOLD_CYC` cycles after the resets were asserted.
- R5: In staged mode (`single_mode_i`=0), releases follow the order calibration, physical medium, coding, error correction. Consecutive releases are at least `HOLD_CYC` cycles apart.
- R6: In simultaneous mode (`single_mode_i`=1), all selected outputs fall on the same clock edge.
- R7: In staged mode with the coding component selected, its reset output stays high for as long as `user_rdy_i` is low.
- R8: `done_o` rises exactly one cycle after the last selected release. It stays high until a new master or direct reset begins.
- R9: A direct input raises only its own component output, one cycle after the input goes high, and drops it one cycle after the input goes low. In idle, `done_o` falls with the direct reset and rises again one cycle after the release.
- R10: A direct input that is high while a master sequence is running sets `err_o`. `err_o` stays high until the next master sequence starts.
- R11: The selection and mode inputs are captured when the sequence starts. Changing them during the sequence does not alter which outputs are released or in what manner.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low synchronous reset of the sequencer |
| mst_rst_i | input | 1 | Asynchronous master reset; the falling edge starts a sequence |
| pll_lock_i | input | 1 | PLL lock indication |
| user_rdy_i | input | 1 | User-ready handshake gating the coding-sublayer release |
| pma_sel_i | input | 1 | Selects calibration and physical-medium components |
| pcs_sel_i | input | 1 | Selects coding and error-correction components |
| single_mode_i | input | 1 | 1 = simultaneous release, 0 = staged release |
| dir_cal_i | input | 1 | Direct reset of the calibration stage |
| dir_pma_i | input | 1 | Direct reset of the physical-medium stage |
| dir_pcs_i | input | 1 | Direct reset of the coding sublayer |
| dir_fec_i | input | 1 | Direct reset of the error-correction stage |
| cal_rst_o | output | 1 | Calibration stage reset |
| pma_rst_o | output | 1 | Physical-medium stage reset |
| pcs_rst_o | output | 1 | Coding sublayer reset |
| fec_rst_o | output | 1 | Error-correction stage reset |
| done_o | output | 1 | Reset complete |
| err_o | output | 1 | Direct reset seen during a master sequence |

## Verification
The hardest case to reach is the coding sublayer held in reset in staged mode after the earlier components have already been released. It needs PLL lock to arrive while user-ready is still low, and user-ready must then stay low long enough for the hold counts of the earlier stages to expire. The stimulus separates the two inputs on purpose: lock is raised first and user-ready after a random or long directed delay. The bench records the cycle at which each output falls and compares the order, the gaps and the done timing against those times. Random trials also change the selection and mode inputs in mid-sequence to show that the captured values are the ones that govern.

// File: rtl/trs_pkg.sv
package trs_pkg;
    localparam int NCOMP = 4;
    // position of the coding sublayer in the release order (0 = first)
    localparam int C_PCS = 2;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HOLD,
        ST_LOCK,
        ST_STEP,
        ST_FIN
    } trs_state_e;
endpackage

// File: rtl/trs_edge_sync.sv
module trs_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic fall_o
);
    logic [STAGES:0] sr_q;

    always_ff @(posedge clk) begin
        if (!rst_n) sr_q <= '0;
        else        sr_q <= {sr_q[STAGES-1:0], async_i};
    end

    assign fall_o = sr_q[STAGES] & ~sr_q[STAGES-1];
endmodule

// File: rtl/trs_direct.sv
module trs_direct #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] req_i,
    output logic [N-1:0] hold_o,
    output logic         any_now_o,
    output logic         any_q_o
);
    always_ff @(posedge clk) begin
        if (!rst_n) hold_o <= '0;
        else        hold_o <= req_i;
    end

    assign any_now_o = |req_i;
    assign any_q_o   = |hold_o;
endmodule

// File: rtl/trs_seq_fsm.sv
module trs_seq_fsm
    import trs_pkg::*;
#(
    parameter int HOLD_CYC = 8,
    parameter int N        = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start_i,
    input  logic [N-1:0] sel_i,
    input  logic         single_i,
    input  logic         pll_lock_i,
    input  logic         user_rdy_i,
    input  logic         dir_now_i,
    input  logic         dir_q_i,
    output logic [N-1:0] rst_o,
    output logic         done_o,
    output logic         err_o,
    output trs_state_e   state_o,
    output logic [N-1:0] sel_o,
    output logic         single_o
);
    localparam int CW = $clog2(HOLD_CYC + 1);
    localparam int IW = $clog2(N);

    trs_state_e   state_q, state_d;
    logic [CW-1:0] cnt_q;
    logic [IW-1:0] idx_q;
    logic [N-1:0]  sel_q, rst_q;
    logic          single_q, done_q, err_q, pend_q;

    logic hold_hit, cur_sel, gated, more, rel_one, skip, start;

    assign hold_hit = (cnt_q == CW'(HOLD_CYC - 1));
    assign cur_sel  = sel_q[idx_q];
    assign gated    = (idx_q == IW'(C_PCS)) && !user_rdy_i;
    assign rel_one  = (state_q == ST_STEP) && cur_sel && hold_hit && !gated;
    assign skip     = (state_q == ST_STEP) && !cur_sel;
    assign start    = (state_q == ST_IDLE) && start_i;

    // any selected component later in the order than the current one
    always_comb begin
        more = 1'b0;
        for (int i = 0; i < N; i++)
            if (i > int'(idx_q) && sel_q[i]) more = 1'b1;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start) state_d = ST_HOLD;
            ST_HOLD: if (hold_hit) state_d = ST_LOCK;
            ST_LOCK: if (pll_lock_i) state_d = single_q ? ST_FIN : ST_STEP;
            ST_STEP: if (rel_one && !more) state_d = ST_FIN;
            ST_FIN:  state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q    <= '0;
            idx_q    <= '0;
            sel_q    <= '0;
            rst_q    <= '0;
            single_q <= 1'b0;
            done_q   <= 1'b0;
            err_q    <= 1'b0;
            pend_q   <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    cnt_q <= '0;
                    idx_q <= '0;
                    if (start) begin
                        sel_q    <= sel_i;
                        single_q <= single_i;
                        rst_q    <= sel_i;
                        done_q   <= 1'b0;
                        err_q    <= 1'b0;
                        pend_q   <= 1'b0;
                    end else if (dir_now_i) begin
                        done_q <= 1'b0;
                        pend_q <= 1'b1;
                    end else if (pend_q && !dir_q_i) begin
                        done_q <= 1'b1;
                        pend_q <= 1'b0;
                    end
                end
                ST_HOLD: cnt_q <= hold_hit ? '0 : cnt_q + CW'(1);
                ST_LOCK: begin
                    cnt_q <= '0;
                    idx_q <= '0;
                    if (pll_lock_i && single_q) rst_q <= '0;
                end
                ST_STEP: begin
                    if (skip) begin
                        idx_q <= idx_q + IW'(1);
                        cnt_q <= '0;
                    end else if (rel_one) begin
                        rst_q[idx_q] <= 1'b0;
                        idx_q <= idx_q + IW'(1);
                        cnt_q <= '0;
                    end else if (!hold_hit) begin
                        cnt_q <= cnt_q + CW'(1);
                    end
                end
                ST_FIN: done_q <= 1'b1;
                default: ;
            endcase
            if (state_q != ST_IDLE && dir_now_i) err_q <= 1'b1;
        end
    end

    assign rst_o    = rst_q;
    assign done_o   = done_q;
    assign err_o    = err_q;
    assign state_o  = state_q;
    assign sel_o    = sel_q;
    assign single_o = single_q;
endmodule

// File: rtl/tx_rst_seq.sv
module tx_rst_seq
    import trs_pkg::*;
#(
    parameter int HOLD_CYC    = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic mst_rst_i,
    input  logic pll_lock_i,
    input  logic user_rdy_i,
    input  logic pma_sel_i,
    input  logic pcs_sel_i,
    input  logic single_mode_i,
    input  logic dir_cal_i,
    input  logic dir_pma_i,
    input  logic dir_pcs_i,
    input  logic dir_fec_i,
    output logic cal_rst_o,
    output logic pma_rst_o,
    output logic pcs_rst_o,
    output logic fec_rst_o,
    output logic done_o,
    output logic err_o
);
    logic             fall, full_sel, dir_now, dir_q;
    logic [NCOMP-1:0] sel_now, dir_req, dir_hold, seq_rst, sel_cap, rst_vec;
    logic             single_cap;
    trs_state_e       st;

    // bit order is the staged release order: cal, pma, pcs, fec
    assign full_sel = !pma_sel_i && !pcs_sel_i;
    assign sel_now  = {pcs_sel_i | full_sel, pcs_sel_i | full_sel,
                       pma_sel_i | full_sel, pma_sel_i | full_sel};
    assign dir_req  = {dir_fec_i, dir_pcs_i, dir_pma_i, dir_cal_i};

    trs_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .async_i(mst_rst_i), .fall_o(fall)
    );

    trs_direct #(.N(NCOMP)) u_dir (
        .clk(clk), .rst_n(rst_n), .req_i(dir_req), .hold_o(dir_hold),
        .any_now_o(dir_now), .any_q_o(dir_q)
    );

    trs_seq_fsm #(.HOLD_CYC(HOLD_CYC), .N(NCOMP)) u_fsm (
        .clk(clk), .rst_n(rst_n), .start_i(fall), .sel_i(sel_now),
        .single_i(single_mode_i), .pll_lock_i(pll_lock_i),
        .user_rdy_i(user_rdy_i), .dir_now_i(dir_now), .dir_q_i(dir_q),
        .rst_o(seq_rst), .done_o(done_o), .err_o(err_o), .state_o(st),
        .sel_o(sel_cap), .single_o(single_cap)
    );

    assign rst_vec   = seq_rst | dir_hold;
    assign cal_rst_o = rst_vec[0];
    assign pma_rst_o = rst_vec[1];
    assign pcs_rst_o = rst_vec[2];
    assign fec_rst_o = rst_vec[3];
endmodule

// File: rtl/trs_chk.sv
module trs_chk
    import trs_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       pll_lock_i,
    input logic       user_rdy_i,
    input logic       done_o,
    input logic       err_o,
    input logic [3:0] rst_vec,
    input logic [3:0] seq_rst,
    input logic [3:0] sel_cap,
    input logic [3:0] dir_hold,
    input logic [3:0] dir_req,
    input logic       single_cap,
    input trs_state_e st
);
    logic busy;
    assign busy = (st != ST_IDLE);

    // R3
    unsel_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> ((rst_vec & ~sel_cap & ~dir_hold) == 4'b0));

    // R4
    lock_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_LOCK && !pll_lock_i) |=> $stable(seq_rst));

    // R5
    stage_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !single_cap) |->
        !((seq_rst[0] && sel_cap[1] && !seq_rst[1]) ||
          (seq_rst[1] && sel_cap[2] && !seq_rst[2]) ||
          (seq_rst[2] && sel_cap[3] && !seq_rst[3])));

    // R6
    same_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && single_cap) |-> (seq_rst == 4'b0 || seq_rst == sel_cap));

    // R7
    rdy_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !single_cap && seq_rst[2] && !user_rdy_i) |=> seq_rst[2]);

    // R8
    done_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (seq_rst == 4'b0));

    // R9
    dir_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|dir_req) |=> ((rst_vec & $past(dir_req)) == $past(dir_req)));

    // R10
    proto_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && |dir_req) |=> err_o);
endmodule

bind tx_rst_seq trs_chk u_chk (
    .clk(clk), .rst_n(rst_n), .pll_lock_i(pll_lock_i), .user_rdy_i(user_rdy_i),
    .done_o(done_o), .err_o(err_o), .rst_vec(rst_vec), .seq_rst(seq_rst),
    .sel_cap(sel_cap), .dir_hold(dir_hold), .dir_req(dir_req),
    .single_cap(single_cap), .st(st)
);

// File: tb/tb_tx_rst_seq.sv
`timescale 1ns/1ps
module tb_tx_rst_seq;
    localparam int HOLD = 8;
    localparam int WDOG = 150000;

    logic clk = 1'b0, rst_n = 1'b0;
    logic mst = 1'b0, lock = 1'b0, rdy = 1'b0, pma_s = 1'b0, pcs_s = 1'b0, single = 1'b0;
    logic [3:0] dir = 4'b0;
    logic cal_r, pma_r, pcs_r, fec_r, done_o, err_o;
    logic [3:0] rvec;

    tx_rst_seq #(.HOLD_CYC(HOLD)) dut (
        .clk(clk), .rst_n(rst_n), .mst_rst_i(mst), .pll_lock_i(lock),
        .user_rdy_i(rdy), .pma_sel_i(pma_s), .pcs_sel_i(pcs_s),
        .single_mode_i(single), .dir_cal_i(dir[0]), .dir_pma_i(dir[1]),
        .dir_pcs_i(dir[2]), .dir_fec_i(dir[3]), .cal_rst_o(cal_r),
        .pma_rst_o(pma_r), .pcs_rst_o(pcs_r), .fec_rst_o(fec_r),
        .done_o(done_o), .err_o(err_o)
    );
    assign rvec = {fec_r, pcs_r, pma_r, cal_r};

    always #2.5 clk = ~clk;

    int cyc = 0, total = 0, bad = 0;
    int rel_t [4];
    int ast_t = -1, done_t = -1;
    logic [3:0] seen = 4'b0, prev = 4'b0;
    logic prev_done = 1'b0;

    always @(negedge clk) begin
        cyc++;
        for (int i = 0; i < 4; i++) begin
            if (prev[i] && !rvec[i]) rel_t[i] = cyc;
            if (!prev[i] && rvec[i]) begin
                seen[i] = 1'b1;
                if (ast_t < 0) ast_t = cyc;
            end
        end
        if (!prev_done && done_o && done_t < 0) done_t = cyc;
        prev = rvec;
        prev_done = done_o;
        if (cyc > WDOG) begin
            total++; bad++;
            $display("FAIL watchdog (all R) actual=%0d expected<%0d", cyc, WDOG);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic clr_mon();
        for (int i = 0; i < 4; i++) rel_t[i] = -1;
        ast_t = -1; done_t = -1; seen = 4'b0;
    endtask

    function automatic logic [3:0] exp_sel(input logic p, input logic c);
        logic f;
        f = !p && !c;
        return {c | f, c | f, p | f, p | f};
    endfunction

    task automatic run_seq(input bit p, input bit c, input bit sm, input bit lock_early,
                           input bit rdy_early, input int rdy_delay, input bit scramble);
        logic [3:0] ex;
        int t_r, minr, maxr, prv;
        string rq;
        ex = exp_sel(p, c);
        pma_s = p; pcs_s = c; single = sm; lock = lock_early; rdy = rdy_early;
        clr_mon();
        mst = 1'b1;
        tick(1 + int'($urandom % 3));
        mst = 1'b0;
        tick(4);
        chk(done_o == 1'b0, "R2", "done after start", done_o, 0);
        chk(err_o == 1'b0, "R2", "err after start", err_o, 0);
        if (!lock_early) begin
            tick(HOLD + 6);
            chk(rvec == ex, "R2", "asserted set", rvec, ex);
            chk(rel_t[0] < 0 && rel_t[1] < 0 && rel_t[2] < 0 && rel_t[3] < 0,
                "R4", "release before lock", rel_t[0] + rel_t[1] + rel_t[2] + rel_t[3], -4);
            if (scramble) begin
                pma_s = ~pma_s; pcs_s = ~pcs_s; single = ~single;
            end
            lock = 1'b1;
        end
        rq = scramble ? "R11" : "R3";
        if (!rdy_early) begin
            tick(rdy_delay);
            if (!sm && ex[2])
                chk(rvec[2] == 1'b1 && rel_t[2] < 0, "R7", "pcs held while not ready", rvec[2], 1);
            t_r = cyc;
            rdy = 1'b1;
        end else t_r = -1;
        for (int k = 0; k < 600 && !done_o; k++) tick(1);
        tick(2);
        chk(seen == ex, rq, "components asserted", seen, ex);
        chk(rvec == 4'b0, rq, "all released", rvec, 0);
        minr = 1 << 30; maxr = -1;
        for (int i = 0; i < 4; i++)
            if (ex[i]) begin
                if (rel_t[i] < minr) minr = rel_t[i];
                if (rel_t[i] > maxr) maxr = rel_t[i];
            end
        chk(minr - ast_t >= HOLD, "R4", "first release delay", minr - ast_t, HOLD);
        if (sm) begin
            chk(minr == maxr, scramble ? "R11" : "R6", "simultaneous spread", maxr - minr, 0);
        end else begin
            prv = -1;
            for (int i = 0; i < 4; i++)
                if (ex[i]) begin
                    if (prv >= 0)
                        chk(rel_t[i] - prv >= HOLD, scramble ? "R11" : "R5",
                            "staged gap", rel_t[i] - prv, HOLD);
                    prv = rel_t[i];
                end
            if (ex[2] && t_r >= 0)
                chk(rel_t[2] > t_r, "R7", "pcs release after ready", rel_t[2], t_r + 1);
        end
        chk(done_t == maxr + 1, "R8", "done timing", done_t, maxr + 1);
        chk(done_o == 1'b1, "R8", "done level", done_o, 1);
        chk(err_o == 1'b0, "R10", "no error", err_o, 0);
    endtask

    task automatic dir_test(input int which, input int len);
        logic [3:0] m;
        m = 4'b1 << which;
        dir = m;
        tick(1);
        chk(rvec == m, "R9", "direct output", rvec, m);
        chk(done_o == 1'b0, "R9", "done drops on direct", done_o, 0);
        tick(len - 1);
        dir = 4'b0;
        tick(1);
        chk(rvec == 4'b0, "R9", "direct release", rvec, 0);
        chk(done_o == 1'b0, "R9", "done not yet", done_o, 0);
        tick(1);
        chk(done_o == 1'b1, "R9", "done after direct", done_o, 1);
        chk(err_o == 1'b0, "R9", "no err in idle", err_o, 0);
    endtask

    initial begin
        void'($urandom(32'd4242));
        for (int i = 0; i < 4; i++) rel_t[i] = -1;
        tick(3);
        chk(rvec == 4'b0, "R1", "resets after rst_n", rvec, 0);
        chk(done_o == 1'b0 && err_o == 1'b0, "R1", "flags after rst_n", {done_o, err_o}, 0);
        rst_n = 1'b1;
        tick(2);
        chk(rvec == 4'b0, "R1", "idle outputs", rvec, 0);

        // directed corners
        run_seq(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 6 * HOLD, 1'b0); // R5 R7 full staged, late ready
        run_seq(1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 20, 1'b0);       // R6 pcs/fec simultaneous
        run_seq(1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 0, 1'b0);        // R3 pma only, lock early
        run_seq(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 4 * HOLD, 1'b1); // R7 R11 pcs only, scrambled

        for (int w = 0; w < 4; w++) dir_test(w, 1 + w);

        // R10: direct reset during a running sequence
        pma_s = 1'b0; pcs_s = 1'b0; single = 1'b0; lock = 1'b0; rdy = 1'b1;
        mst = 1'b1; tick(1); mst = 1'b0;
        tick(HOLD + 6);
        dir = 4'b1000; tick(1); dir = 4'b0; tick(1);
        chk(err_o == 1'b1, "R10", "err on direct in sequence", err_o, 1);
        lock = 1'b1;
        for (int k = 0; k < 600 && !done_o; k++) tick(1);
        tick(1);
        chk(err_o == 1'b1, "R10", "err sticky", err_o, 1);

        // constrained random trials
        for (int t = 0; t < 24; t++) begin
            bit le, re;
            le = ($urandom % 3) == 0;
            re = ($urandom % 2) == 0;
            run_seq(1'($urandom), 1'($urandom), 1'($urandom), le, re,
                    int'($urandom % 60), !le && (($urandom % 2) == 0));
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule